// File: doc/BRIEF.md
# Transmit-Empty Interrupt Request Generator

This block produces the "transmit holding stage empty" interrupt request of a serial transmitter. It watches the fill level of the transmit FIFO. When the FIFO runs dry, it raises its request either at once or after a short hold-off. It raises it at once when the FIFO held two or more characters together at some point since it last went empty. Otherwise it waits for the bit times of one character frame without the stop bit. The hold-off stops a flood of empty interrupts at start-up, when software writes one character at a time. It gives the host time to write the next character before any interrupt has to be decoded.

The request goes to the interrupt priority encoder as the third-level source, reported with identification code 001. It is withdrawn when the host writes the holding register. It is also withdrawn when the host reads the identification register while the priority encoder flags this source as the one being reported. The FIFO storage, the shift register and the baud generator are outside the block. It only receives the FIFO level, the write and read strobes, a one-cycle tick per bit time and the frame format.

Top module: `tx_empty_irq`

## Requirements
- R1: While reset is asserted and on the first clock after it, `irq` is 0. The "held two characters" record starts cleared.
- R2: The FIFO may have reached a level of 2 or more since its previous empty entry. When its level then becomes 0, `irq` is 1 after the first clock edge that samples level 0.
- R3: The FIFO may instead not have reached level 2 since its previous empty entry. Then `irq` stays 0 until the Nth `baud_tick` sampled after the empty entry, and goes to 1 on that edge. N = 1 + (5 + `data_len`) + `parity_on`, where `data_len` encodes 0 = 5, 1 = 6, 2 = 7 and 3 = 8 data bits.
- R4: `thr_wr` clears `irq` on the next edge. It also cancels a running hold-off, so a later empty entry starts a fresh full count.
- R5: `iir_rd` together with `iir_top` = 1 clears `irq` on the next edge. `iir_rd` with `iir_top` = 0 leaves `irq` unchanged.
- R6: The "held two characters" record is cleared at every empty entry. A second emptying with only one character written in between uses the hold-off.
- R7: Out of reset with an empty FIFO, the first empty event is the reset state itself. It uses the hold-off, so `irq` only rises after N ticks.
- R8: The frame format is captured at the empty entry, and later changes do not alter the running count. Baud ticks while the FIFO is non-empty do not raise `irq`.
- R9: A clear (by write or by a reported read) in the same cycle as the hold-off expiring leaves `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | LEVEL_W | Current transmit FIFO fill level |
| thr_wr | input | 1 | Host write strobe to the holding register |
| iir_rd | input | 1 | Identification register read strobe |
| iir_top | input | 1 | This source is the one the identification register reports |
| baud_tick | input | 1 | One-cycle pulse per transmit bit time |
| data_len | input | 2 | Data bits per character, 0..3 for 5..8 |
| parity_on | input | 1 | Frame carries a parity bit |
| irq | output | 1 | Empty interrupt request to the priority encoder |

## Verification
On every cycle, the assertions check the clearing rules (R4, R5), the immediate set after a well-filled FIFO drains (R2), and the clearing of the fill record at each empty entry (R6). They also check that the request only rises on an empty FIFO and that the hold-off counter stays within one frame length. The exact count of ticks before a delayed request (R3, R7), and the capture of the frame format at the empty entry (R8), depend on history longer than a simple property can hold. So do the cancelling of a running hold-off by a write and the clear-beats-set ordering (R4, R9). Only the bench's directed and random scenarios, compared against its cycle model, show these.

// File: rtl/tei_pkg.sv
package tei_pkg;

   // Data length encoding: 0..3 select 5..8 data bits.
   localparam int DATA_MIN   = 5;
   localparam int FRAME_MAX  = 1 + 8 + 1;   // start + 8 data + parity

   typedef enum logic [1:0] {
      DLEN_5 = 2'd0,
      DLEN_6 = 2'd1,
      DLEN_7 = 2'd2,
      DLEN_8 = 2'd3
   } dlen_e;

   // Bit times in a frame that come before the stop bit.
   function automatic int unsigned pre_stop_bits(input logic [1:0] dlen,
                                                 input logic       par);
      int unsigned n;
      n = 1 + DATA_MIN + int'(dlen) + (par ? 1 : 0);
      return n;
   endfunction

endpackage

// File: rtl/tei_fill_tracker.sv
module tei_fill_tracker #(
   parameter int LEVEL_W  = 5,
   parameter int HOLD_MIN = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] fifo_level,
   output logic               empty,
   output logic               entry,
   output logic               hold_seen
);

   localparam logic [LEVEL_W-1:0] HOLD_LVL = LEVEL_W'(HOLD_MIN);

   logic empty_q;
   logic reached;

   assign empty   = (fifo_level == '0);
   assign reached = (fifo_level >= HOLD_LVL);

   // Cleared at reset, so the reset state counts as the first empty entry.
   assign entry = empty && !empty_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b0;
      end else begin
         empty_q <= empty;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_seen <= 1'b0;
      end else if (entry) begin
         hold_seen <= 1'b0;
      end else if (reached) begin
         hold_seen <= 1'b1;
      end
   end

endmodule

// File: rtl/tei_char_timer.sv
module tei_char_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             tick,
   input  logic [CNT_W-1:0] load_bits,
   output logic             expire,
   output logic             busy,
   output logic [CNT_W-1:0] count
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic last_bit;

   assign last_bit = (count == LAST);
   assign expire   = busy && tick && last_bit && !abort && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         count <= '0;
      end else if (abort) begin
         busy  <= 1'b0;
         count <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         count <= load_bits;
      end else if (busy && tick) begin
         if (last_bit) begin
            busy  <= 1'b0;
            count <= '0;
         end else begin
            count <= count - LAST;
         end
      end
   end

endmodule

// File: rtl/tei_req_latch.sv
module tei_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_now,
   input  logic set_late,
   input  logic clr_wr,
   input  logic clr_rd,
   output logic irq
);

   logic clr;
   logic set;

   assign clr = clr_wr || clr_rd;
   assign set = set_now || set_late;

   // A clear in the same cycle as a set wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (clr) begin
         irq <= 1'b0;
      end else if (set) begin
         irq <= 1'b1;
      end
   end

endmodule

// File: rtl/tx_empty_irq.sv
module tx_empty_irq
   import tei_pkg::*;
#(
   parameter int LEVEL_W     = 5,
   parameter int HOLD_MIN    = 2,
   parameter int CNT_W       = 4,
   parameter bit FIXED_FRAME = 1'b0,
   parameter int FIXED_BITS  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               thr_wr,
   input  logic               iir_rd,
   input  logic               iir_top,
   input  logic               baud_tick,
   input  logic [1:0]         data_len,
   input  logic               parity_on,
   output logic               irq
);

   localparam int MAX_BITS = FIXED_FRAME ? FIXED_BITS : FRAME_MAX;

   // Elaboration-time parameter checks.
   if (LEVEL_W < 2) begin : g_bad_level
      $error("tx_empty_irq: LEVEL_W must be at least 2");
   end
   if (HOLD_MIN < 2 || HOLD_MIN >= (1 << LEVEL_W)) begin : g_bad_hold
      $error("tx_empty_irq: HOLD_MIN out of range for LEVEL_W");
   end
   if ((1 << CNT_W) <= MAX_BITS) begin : g_bad_cnt
      $error("tx_empty_irq: CNT_W too narrow for the frame length");
   end
   if (FIXED_FRAME && FIXED_BITS < 1) begin : g_bad_fixed
      $error("tx_empty_irq: FIXED_BITS must be positive");
   end

   logic             empty_w;
   logic             entry_w;
   logic             hold_w;
   logic             busy_w;
   logic             expire_w;
   logic [CNT_W-1:0] count_w;
   logic [CNT_W-1:0] load_w;
   logic             start_w;
   logic             abort_w;
   logic             clr_rd_w;

   // Frame length source: fixed constant or decoded from the format inputs.
   if (FIXED_FRAME) begin : g_fixed_frame
      assign load_w = CNT_W'(FIXED_BITS);
   end else begin : g_var_frame
      assign load_w = CNT_W'(pre_stop_bits(data_len, parity_on));
   end

   tei_fill_tracker #(
      .LEVEL_W  (LEVEL_W),
      .HOLD_MIN (HOLD_MIN)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_level (fifo_level),
      .empty      (empty_w),
      .entry      (entry_w),
      .hold_seen  (hold_w)
   );

   assign start_w  = entry_w && !hold_w;
   assign abort_w  = thr_wr || !empty_w;
   assign clr_rd_w = iir_rd && iir_top;

   tei_char_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_w),
      .abort     (abort_w),
      .tick      (baud_tick),
      .load_bits (load_w),
      .expire    (expire_w),
      .busy      (busy_w),
      .count     (count_w)
   );

   tei_req_latch u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_now  (entry_w && hold_w),
      .set_late (expire_w),
      .clr_wr   (thr_wr),
      .clr_rd   (clr_rd_w),
      .irq      (irq)
   );

endmodule

// File: rtl/tei_checks.sv
module tei_checks #(
   parameter int LEVEL_W  = 5,
   parameter int CNT_W    = 4,
   parameter int MAX_BITS = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LEVEL_W-1:0] fifo_level,
   input logic               thr_wr,
   input logic               iir_rd,
   input logic               iir_top,
   input logic               irq,
   input logic               entry,
   input logic               hold_seen,
   input logic               busy,
   input logic [CNT_W-1:0]   count
);

   a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !irq)
      else $error("R1: request high after reset");

   a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !irq)
      else $error("R4: request survived a write");

   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      iir_rd && iir_top |=> !irq)
      else $error("R5: request survived a reported read");

   a_r5_other_read_kept: assert property (@(posedge clk) disable iff (!rst_n)
      irq && iir_rd && !iir_top && !thr_wr |=> irq)
      else $error("R5: request dropped by an unrelated read");

   a_r2_immediate_set: assert property (@(posedge clk) disable iff (!rst_n)
      entry && hold_seen && !thr_wr && !(iir_rd && iir_top) |=> irq)
      else $error("R2: no immediate request after a filled FIFO drained");

   a_r6_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> !hold_seen)
      else $error("R6: fill record kept across an empty entry");

   a_r3_set_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fifo_level) == '0)
      else $error("R3: request rose while the FIFO held data");

   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (count != '0 && int'(count) <= MAX_BITS))
      else $error("R3: hold-off count out of range");

endmodule

bind tx_empty_irq tei_checks #(
   .LEVEL_W  (LEVEL_W),
   .CNT_W    (CNT_W),
   .MAX_BITS (MAX_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fifo_level (fifo_level),
   .thr_wr     (thr_wr),
   .iir_rd     (iir_rd),
   .iir_top    (iir_top),
   .irq        (irq),
   .entry      (entry_w),
   .hold_seen  (hold_w),
   .busy       (busy_w),
   .count      (count_w)
);

// File: tb/sim_tx_empty_irq.sv
module sim_tx_empty_irq;

   localparam int LW = 5;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] lvl = '0;
   logic          wr = 1'b0, rd = 1'b0, top = 1'b0, tick = 1'b0;
   logic [1:0]    dlen = 2'd3;
   logic          par = 1'b0;
   logic          irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;   // 50 MHz

   tx_empty_irq u0 (
      .clk(clk), .rst_n(rst_n), .fifo_level(lvl), .thr_wr(wr),
      .iir_rd(rd), .iir_top(top), .baud_tick(tick),
      .data_len(dlen), .parity_on(par), .irq(irq)
   );

   // Expected hold-off length from the requirement formula (R3).
   function automatic int frame_n(input logic [1:0] d, input logic p);
      return 1 + 5 + int'(d) + (p ? 1 : 0);
   endfunction

   // Cycle model of the requirements.
   logic m_empty_q, m_hold, m_busy, m_irq;
   int   m_cnt;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_empty_q <= 1'b0; m_hold <= 1'b0; m_busy <= 1'b0;
         m_irq <= 1'b0; m_cnt <= 0;
      end else begin
         automatic bit emp  = (lvl == '0);
         automatic bit ent  = emp && !m_empty_q;
         automatic bit late = 1'b0;
         automatic bit setn = ent && m_hold;
         m_empty_q <= emp;
         if (ent) m_hold <= 1'b0;
         else if (int'(lvl) >= 2) m_hold <= 1'b1;
         if (wr || !emp) m_busy <= 1'b0;
         else if (ent && !m_hold) begin
            m_busy <= 1'b1; m_cnt <= frame_n(dlen, par);
         end else if (m_busy && tick) begin
            if (m_cnt == 1) begin m_busy <= 1'b0; late = 1'b1; end
            else m_cnt <= m_cnt - 1;
         end
         if (wr || (rd && top)) m_irq <= 1'b0;
         else if (setn || late) m_irq <= 1'b1;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one cycle of inputs at a falling edge, then compare at the next one.
   task automatic cyc(input int l, input bit w, input bit r, input bit t,
                      input bit tk);
      lvl = LW'(l); wr = w; rd = r; top = t; tick = tk;
      @(negedge clk);
      chk(cur_req, irq, m_irq);
   endtask

   task automatic ticks(input int l, input int n);
      for (int i = 0; i < n; i++) cyc(l, 0, 0, 0, 1);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      finish_run();
   end

   initial begin
      int level;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", irq, 1'b0);
      rst_n = 1'b1;
      dlen = 2'd3; par = 1'b0;                 // N = 9

      // R7: start-up empty entry uses the hold-off.
      cur_req = "R7";
      cyc(0, 0, 0, 0, 0);
      chk("R1", irq, 1'b0);
      ticks(0, 8);
      chk("R7", irq, 1'b0);
      ticks(0, 1);
      chk("R7", irq, 1'b1);

      // R5: unrelated read keeps, reported read clears.
      cur_req = "R5";
      cyc(0, 0, 1, 0, 0);
      chk("R5", irq, 1'b1);
      cyc(0, 0, 1, 1, 0);
      chk("R5", irq, 1'b0);

      // R2: fill to 3, drain, immediate request.
      cur_req = "R2";
      cyc(1, 1, 0, 0, 0); cyc(2, 1, 0, 0, 0); cyc(3, 1, 0, 0, 0);
      cyc(2, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0);
      chk("R2", irq, 1'b1);

      // R4: write clears.
      cur_req = "R4";
      cyc(1, 1, 0, 0, 0);
      chk("R4", irq, 1'b0);

      // R6 / R3: only one character since last empty -> hold-off of 9.
      cur_req = "R6";
      cyc(0, 0, 0, 0, 0);
      chk("R6", irq, 1'b0);
      ticks(0, 8);
      chk("R3", irq, 1'b0);
      ticks(0, 1);
      chk("R3", irq, 1'b1);

      // R3: 5 data bits with parity -> N = 7.
      cur_req = "R3";
      cyc(1, 1, 0, 0, 0);
      dlen = 2'd0; par = 1'b1;
      cyc(0, 0, 0, 0, 0);
      ticks(0, 6);
      chk("R3", irq, 1'b0);
      ticks(0, 1);
      chk("R3", irq, 1'b1);

      // R4: write cancels a running hold-off; next entry counts afresh.
      cur_req = "R4";
      cyc(1, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      ticks(0, 3);
      cyc(1, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      ticks(0, 6);
      chk("R4", irq, 1'b0);
      ticks(0, 1);
      chk("R4", irq, 1'b1);

      // R8: format captured at entry; ticks with data present do nothing.
      cur_req = "R8";
      cyc(1, 1, 0, 0, 0);
      ticks(1, 20);
      chk("R8", irq, 1'b0);
      cyc(0, 0, 0, 0, 0);                      // loads 7
      dlen = 2'd3; par = 1'b0;
      ticks(0, 7);
      chk("R8", irq, 1'b1);

      // R9: reported read on the expiry cycle wins.
      cur_req = "R9";
      cyc(1, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);                      // loads 9
      ticks(0, 8);
      cyc(0, 0, 1, 1, 1);
      chk("R9", irq, 1'b0);
      cyc(0, 0, 0, 0, 0);
      chk("R9", irq, 1'b0);

      // Constrained random mix against the cycle model.
      cur_req = "R3";
      void'($urandom(32'h5EED_0C1E));
      level = 0;
      for (int i = 0; i < 4000; i++) begin
         automatic bit w  = (level < DEPTH) && ($urandom_range(0, 5) == 0);
         automatic bit dr = !w && level > 0 && ($urandom_range(0, 3) == 0);
         automatic bit r  = ($urandom_range(0, 9) == 0);
         automatic bit t  = $urandom_range(0, 1);
         automatic bit tk = ($urandom_range(0, 2) == 0);
         if (w) level++;
         else if (dr) level--;
         if ($urandom_range(0, 63) == 0) begin
            dlen = 2'($urandom_range(0, 3));
            par  = 1'($urandom_range(0, 1));
         end
         cyc(level, w, r, t, tk);
      end

      finish_run();
   end

endmodule